// File: doc/BRIEF.md
# Fully Associative Address Translation Cache

This block caches virtual-to-physical page translations for a 32-bit virtual address space with 4 KiB pages. A requester presents a virtual address with a valid/ready handshake. The upper 20 bits (the virtual page number) are compared against every valid entry in parallel. On a match the physical address is returned in the same cycle. On a miss the requester is told at once, the block stops accepting requests, and it waits for the page walker to deliver either a translation or a fault.

A delivered translation is written into the lowest-numbered empty slot. If no slot is empty, it replaces the slot whose last use is oldest. Recency is kept as a per-entry age rank. Three saturating counters record hits, misses and faults. A synchronous flush input empties the cache.

Top module: `xlate_buf`

## Requirements
- R1: After reset every entry is invalid, all three counters read zero, `req_ready` is high and `rsp_valid` is low with no request; the first lookup of any address misses.
- R2: A request accepted while the page number matches a valid entry gives, in the same cycle, `rsp_valid`=1, `rsp_kind`=2'b01 (hit) and `rsp_paddr` = {stored physical page, `req_vaddr[11:0]`}.
- R3: A request accepted with no matching entry gives, in the same cycle, `rsp_valid`=1 and `rsp_kind`=2'b10 (miss). `req_ready` then stays low until the cycle after `fill_valid` is seen.
- R4: A walk result with `fill_fault`=0 gives, in its cycle, `rsp_valid`=1, `rsp_kind`=2'b00 (filled) and `rsp_paddr` = {`fill_ppn`, offset of the missed address}. It installs `fill_vpn`/`fill_ppn` in the lowest-index invalid entry, or if all are valid in the least recently used entry.
- R5: A walk result with `fill_fault`=1 gives `rsp_valid`=1, `rsp_kind`=2'b11 (fault) and `rsp_paddr`=0, and installs nothing.
- R6: A hit or an install makes that entry the most recently used; entries used more recently than it keep their order behind it.
- R7: `hit_count` rises by one per hit, `miss_count` by one per missed lookup (whether the walk then faults or not), and `fault_count` by one per faulting walk result. Each counter stops at all ones.
- R8: `flush` clears every valid bit at the next edge. A lookup in the same cycle is answered from the contents before the flush. A successful walk result in the same cycle installs nothing.
- R9: While waiting for the walker, a raised `req_valid` gets no response. A `fill_valid` raised while no walk is pending is ignored: no response, no counter change, no install.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Empty all entries |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_kind | output | 2 | 00 filled, 01 hit, 10 miss, 11 fault |
| rsp_paddr | output | 32 | Physical address (hit or filled) |
| fill_valid | input | 1 | Walker result present |
| fill_fault | input | 1 | Walker result is a fault |
| fill_vpn | input | 20 | Virtual page number of the result |
| fill_ppn | input | 20 | Physical page number of the result |
| hit_count | output | CNT_W | Saturating hit counter |
| miss_count | output | CNT_W | Saturating miss counter |
| fault_count | output | CNT_W | Saturating fault counter |

## Verification
The hardest state to reach from the ports is a full cache whose recency order has been shuffled by interleaved hits. Only that state shows which entry a replacement picks. The bench drives a long pseudo-random stream over seven page numbers, more than the four slots. Faults and flushes fall in at fixed points. A bench-side model of ranks and slots predicts every hit, miss and victim. The counters are built 4 bits wide in the bench, so saturation is reached within the same run.

// File: rtl/xlate_pkg.sv
// Shared widths and response encoding for the translation cache.
package xlate_pkg;
    localparam int VA_W  = 32;
    localparam int OFS_W = 12;
    localparam int PN_W  = VA_W - OFS_W;

    typedef enum logic [1:0] {
        RSP_FILLED = 2'b00,
        RSP_HIT    = 2'b01,
        RSP_MISS   = 2'b10,
        RSP_FAULT  = 2'b11
    } rsp_kind_e;
endpackage

// File: rtl/xlate_match.sv
// Parallel tag compare. Assumes at most one valid entry holds a given
// page number; with several, the highest index is reported.
module xlate_match #(
    parameter int N_ENT = 4,
    parameter int TAG_W = 20,
    localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic [N_ENT-1:0]            valid,
    input  logic [N_ENT-1:0][TAG_W-1:0] tags,
    input  logic [TAG_W-1:0]            key,
    output logic                        hit,
    output logic [IDX_W-1:0]            hit_idx
);
    logic [N_ENT-1:0] match;

    // one comparator per entry
    for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
        assign match[g] = valid[g] && (tags[g] == key);
    end

    // encode the matching entry
    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < N_ENT; i++) begin
            if (match[i]) hit_idx = IDX_W'(i);
        end
    end

    assign hit = |match;
endmodule

// File: rtl/xlate_recency.sv
// Age ranks (0 = newest, N_ENT-1 = oldest) and victim choice. Ranks always
// form a permutation; reset gives entry i rank i. Assumes N_ENT is a power of two.
module xlate_recency #(
    parameter int N_ENT = 4,
    localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch,
    input  logic [IDX_W-1:0] touch_idx,
    input  logic [N_ENT-1:0] valid,
    output logic [IDX_W-1:0] victim_idx
);
    logic [N_ENT-1:0][IDX_W-1:0] rank_q;
    logic [IDX_W-1:0]            touched_rank;

    assign touched_rank = rank_q[touch_idx];

    // age update: the touched entry becomes newest, younger ones age by one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_ENT; i++) rank_q[i] <= IDX_W'(i);
        end else if (touch) begin
            for (int i = 0; i < N_ENT; i++) begin
                if (IDX_W'(i) == touch_idx)         rank_q[i] <= '0;
                else if (rank_q[i] < touched_rank)  rank_q[i] <= rank_q[i] + 1'b1;
            end
        end
    end

    // victim: lowest-index empty slot, else the oldest rank
    always_comb begin
        victim_idx = '0;
        if (&valid) begin
            for (int i = 0; i < N_ENT; i++) begin
                if (rank_q[i] == IDX_W'(N_ENT - 1)) victim_idx = IDX_W'(i);
            end
        end else begin
            for (int i = N_ENT - 1; i >= 0; i--) begin
                if (!valid[i]) victim_idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/xlate_satcnt.sv
// Event counter that stops at all ones.
module xlate_satcnt #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    // count up, hold at the top
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt <= '0;
        else if (inc && !(&cnt))   cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/xlate_buf.sv
// Fully associative translation cache, 4 KiB pages. A hit answers in the
// request cycle; a miss answers "miss" and stalls requests until the walker
// returns. Assumes the walker returns the page number that missed.
module xlate_buf
    import xlate_pkg::*;
#(
    parameter int N_ENT = 4,
    parameter int CNT_W = 32,
    localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    output logic             rsp_valid,
    output logic [1:0]       rsp_kind,
    output logic [VA_W-1:0]  rsp_paddr,
    input  logic             fill_valid,
    input  logic             fill_fault,
    input  logic [PN_W-1:0]  fill_vpn,
    input  logic [PN_W-1:0]  fill_ppn,
    output logic [CNT_W-1:0] hit_count,
    output logic [CNT_W-1:0] miss_count,
    output logic [CNT_W-1:0] fault_count
);
    typedef enum logic {ST_IDLE, ST_WAIT} state_e;

    state_e                     st_q;
    logic [OFS_W-1:0]           ofs_q;
    logic [N_ENT-1:0]           ent_valid;
    logic [N_ENT-1:0][PN_W-1:0] ent_vpn;
    logic [N_ENT-1:0][PN_W-1:0] ent_ppn;

    logic             hit;
    logic [IDX_W-1:0] hit_idx;
    logic [IDX_W-1:0] victim_idx;
    logic             lookup, do_hit, do_miss, walk_end, do_fault, do_install;
    rsp_kind_e        kind;

    assign req_ready  = (st_q == ST_IDLE);
    assign lookup     = req_valid && req_ready;
    assign do_hit     = lookup && hit;
    assign do_miss    = lookup && !hit;
    assign walk_end   = (st_q == ST_WAIT) && fill_valid;
    assign do_fault   = walk_end && fill_fault;
    assign do_install = walk_end && !fill_fault && !flush;

    xlate_match #(.N_ENT(N_ENT), .TAG_W(PN_W)) u_match (
        .valid   (ent_valid),
        .tags    (ent_vpn),
        .key     (req_vaddr[VA_W-1:OFS_W]),
        .hit     (hit),
        .hit_idx (hit_idx)
    );

    xlate_recency #(.N_ENT(N_ENT)) u_age (
        .clk        (clk),
        .rst_n      (rst_n),
        .touch      (do_hit || do_install),
        .touch_idx  (do_hit ? hit_idx : victim_idx),
        .valid      (ent_valid),
        .victim_idx (victim_idx)
    );

    // response mux: lookup result or walk outcome
    always_comb begin
        rsp_valid = lookup || walk_end;
        kind      = RSP_MISS;
        rsp_paddr = '0;
        if (lookup) begin
            if (hit) begin
                kind      = RSP_HIT;
                rsp_paddr = {ent_ppn[hit_idx], req_vaddr[OFS_W-1:0]};
            end
        end else if (walk_end) begin
            if (fill_fault) begin
                kind = RSP_FAULT;
            end else begin
                kind      = RSP_FILLED;
                rsp_paddr = {fill_ppn, ofs_q};
            end
        end
    end
    assign rsp_kind = kind;

    // request/walk sequencing and saved page offset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            ofs_q <= '0;
        end else if (do_miss) begin
            st_q  <= ST_WAIT;
            ofs_q <= req_vaddr[OFS_W-1:0];
        end else if (walk_end) begin
            st_q  <= ST_IDLE;
        end
    end

    // valid bits: flush wins over install
    always_ff @(posedge clk) begin
        if (!rst_n)          ent_valid <= '0;
        else if (flush)      ent_valid <= '0;
        else if (do_install) ent_valid[victim_idx] <= 1'b1;
    end

    // translation payload, written on install only
    always_ff @(posedge clk) begin
        if (do_install) begin
            ent_vpn[victim_idx] <= fill_vpn;
            ent_ppn[victim_idx] <= fill_ppn;
        end
    end

    xlate_satcnt #(.W(CNT_W)) u_hits   (.clk(clk), .rst_n(rst_n), .inc(do_hit),   .cnt(hit_count));
    xlate_satcnt #(.W(CNT_W)) u_misses (.clk(clk), .rst_n(rst_n), .inc(do_miss),  .cnt(miss_count));
    xlate_satcnt #(.W(CNT_W)) u_faults (.clk(clk), .rst_n(rst_n), .inc(do_fault), .cnt(fault_count));
endmodule

// File: rtl/xlate_buf_chk.sv
// Port-level protocol and counter properties for xlate_buf.
module xlate_buf_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [31:0]      req_vaddr,
    input logic             rsp_valid,
    input logic [1:0]       rsp_kind,
    input logic [31:0]      rsp_paddr,
    input logic             fill_valid,
    input logic             fill_fault,
    input logic [19:0]      fill_ppn,
    input logic [CNT_W-1:0] hit_count,
    input logic [CNT_W-1:0] miss_count,
    input logic [CNT_W-1:0] fault_count
);
    // R2
    hit_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind == 2'b01) |-> (req_valid && req_ready && rsp_paddr[11:0] == req_vaddr[11:0]));
    // R3
    miss_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && rsp_kind == 2'b10) |=> !req_ready);
    // R4
    fill_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind == 2'b00) |-> (fill_valid && !fill_fault && rsp_paddr[31:12] == fill_ppn));
    // R5
    fault_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind == 2'b11) |-> (fill_valid && fill_fault && rsp_paddr == 32'd0));
    // R7
    hit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind == 2'b01) |=> (hit_count == $past(hit_count) + 1'b1 || &$past(hit_count)));
    // R7
    hit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_valid && rsp_kind == 2'b01) |=> $stable(hit_count));
    // R7
    miss_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind == 2'b10) |=> (miss_count == $past(miss_count) + 1'b1 || &$past(miss_count)));
    // R7
    fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_valid && rsp_kind == 2'b11) |=> $stable(fault_count));
    // R9
    wait_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && !fill_valid) |-> !rsp_valid);
endmodule

bind xlate_buf xlate_buf_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_xlate_buf.sv
// Self-checking bench: directed corners plus a long pseudo-random sweep
// against a bench-side slot/rank model. Counters are 4 bits wide here.
module tb_xlate_buf;
    localparam int N  = 4;
    localparam int CW = 4;
    localparam int CMAX = (1 << CW) - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        rsp_valid;
    logic [1:0]  rsp_kind;
    logic [31:0] rsp_paddr;
    logic        fill_valid = 1'b0;
    logic        fill_fault = 1'b0;
    logic [19:0] fill_vpn = '0;
    logic [19:0] fill_ppn = '0;
    logic [CW-1:0] hit_count, miss_count, fault_count;

    always #5 clk = ~clk;

    xlate_buf #(.N_ENT(N), .CNT_W(CW)) dut (.*);

    int nchk = 0;
    int nfail = 0;
    bit done = 0;

    // bench model
    bit          mv[N];
    logic [19:0] mvpn[N];
    logic [19:0] mppn[N];
    int          mrank[N];
    int          mh = 0, mm = 0, mf = 0;
    logic [11:0] pend_ofs;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    function automatic int sat(input int x);
        return (x < CMAX) ? x + 1 : CMAX;
    endfunction

    function automatic int m_find(input logic [19:0] vpn);
        for (int i = 0; i < N; i++) if (mv[i] && mvpn[i] == vpn) return i;
        return -1;
    endfunction

    function automatic void m_touch(input int t);
        int rt = mrank[t];
        for (int j = 0; j < N; j++) begin
            if (j == t) mrank[j] = 0;
            else if (mrank[j] < rt) mrank[j] = mrank[j] + 1;
        end
    endfunction

    function automatic int m_victim();
        for (int i = 0; i < N; i++) if (!mv[i]) return i;
        for (int i = 0; i < N; i++) if (mrank[i] == N - 1) return i;
        return 0;
    endfunction

    task automatic chk_counts(input string tag);
        chk({tag, " hit_count"},   32'(hit_count),   32'(mh));
        chk({tag, " miss_count"},  32'(miss_count),  32'(mm));
        chk({tag, " fault_count"}, 32'(fault_count), 32'(mf));
    endtask

    // one request; with_flush raises flush in the same cycle
    task automatic lookup(input logic [31:0] va, input bit with_flush, output bit was_hit);
        int idx;
        @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = va;
        flush     = with_flush;
        #4;
        idx = m_find(va[31:12]);
        was_hit = (idx >= 0);
        chk("R2/R3 rsp_valid on request", 32'(rsp_valid), 32'd1);
        if (was_hit) begin
            chk("R2 hit kind", 32'(rsp_kind), 32'd1);
            chk("R2 hit paddr", rsp_paddr, {mppn[idx], va[11:0]});
        end else begin
            chk("R3 miss kind", 32'(rsp_kind), 32'd2);
        end
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        flush     = 1'b0;
        if (was_hit) begin
            m_touch(idx);
            mh = sat(mh);
        end else begin
            mm = sat(mm);
            pend_ofs = va[11:0];
        end
        if (with_flush) for (int i = 0; i < N; i++) mv[i] = 0;
        chk_counts("R7");
        if (!was_hit) chk("R3 stall after miss", 32'(req_ready), 32'd0);
    endtask

    // one walker result; with_flush raises flush in the same cycle
    task automatic walk(input logic [19:0] vpn, input logic [19:0] ppn, input bit fault, input bit with_flush);
        int v;
        @(negedge clk);
        fill_valid = 1'b1;
        fill_fault = fault;
        fill_vpn   = vpn;
        fill_ppn   = ppn;
        flush      = with_flush;
        #4;
        chk("R4/R5 rsp_valid on walk end", 32'(rsp_valid), 32'd1);
        if (fault) begin
            chk("R5 fault kind", 32'(rsp_kind), 32'd3);
            chk("R5 fault paddr", rsp_paddr, 32'd0);
        end else begin
            chk("R4 filled kind", 32'(rsp_kind), 32'd0);
            chk("R4 filled paddr", rsp_paddr, {ppn, pend_ofs});
        end
        @(posedge clk);
        #1;
        fill_valid = 1'b0;
        fill_fault = 1'b0;
        flush      = 1'b0;
        if (fault) begin
            mf = sat(mf);
        end else if (!with_flush) begin
            v = m_victim();
            mv[v] = 1; mvpn[v] = vpn; mppn[v] = ppn;
            m_touch(v);
        end
        if (with_flush) for (int i = 0; i < N; i++) mv[i] = 0;
        chk("R3 ready after walk", 32'(req_ready), 32'd1);
        chk_counts("R7");
    endtask

    // request plus walk if it missed
    task automatic access(input logic [31:0] va, input bit fault);
        bit h;
        lookup(va, 1'b0, h);
        if (!h) walk(va[31:12], va[31:12] ^ 20'h5A5A5, fault, 1'b0);
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(posedge clk);
        #1;
        flush = 1'b0;
        for (int i = 0; i < N; i++) mv[i] = 0;
    endtask

    // watchdog
    initial begin
        #2_000_000;
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        bit h;
        logic [19:0] pool[7];
        int unsigned s;
        pool = '{20'h00000, 20'h00001, 20'h00402, 20'h00403, 20'h00804, 20'h00805, 20'hFFFFF};
        for (int i = 0; i < N; i++) begin mv[i] = 0; mrank[i] = i; mvpn[i] = '0; mppn[i] = '0; end

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 req_ready after reset", 32'(req_ready), 32'd1);
        chk("R1 rsp_valid idle", 32'(rsp_valid), 32'd0);
        chk_counts("R1");

        // R1 first lookup misses, then fill and hit
        lookup(32'h0000_0ABC, 1'b0, h);
        chk("R1 first lookup misses", 32'(h), 32'd0);
        // R9: request while waiting is ignored
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = 32'h0040_2000;
        #4;
        chk("R9 no response while waiting", 32'(rsp_valid), 32'd0);
        chk("R9 ready low while waiting", 32'(req_ready), 32'd0);
        @(posedge clk); #1 req_valid = 1'b0;
        chk_counts("R9");
        walk(20'h00000, 20'h0A000, 1'b0, 1'b0);
        lookup(32'h0000_0123, 1'b0, h);
        chk("R4 installed entry hits", 32'(h), 32'd1);

        // fill the rest, then shuffle recency and force an eviction (R6)
        access(32'h0000_1004, 1'b0);
        access(32'h0040_2008, 1'b0);
        access(32'h0040_300C, 1'b0);
        access(32'h0000_0010, 1'b0);          // entry 0 newest, entry 1 oldest
        access(32'h0080_4FFF, 1'b0);          // evicts page 00001
        lookup(32'h0000_1000, 1'b0, h);
        chk("R6 oldest entry was replaced", 32'(h), 32'd0);
        walk(20'h00001, 20'h0B000, 1'b0, 1'b0);

        // R5 fault installs nothing
        lookup(32'h1234_5678, 1'b0, h);
        walk(20'h12345, 20'h77777, 1'b1, 1'b0);
        lookup(32'h1234_5000, 1'b0, h);
        chk("R5 faulting page still misses", 32'(h), 32'd0);
        walk(20'h12345, 20'h77777, 1'b1, 1'b0);

        // R9: stray walker result while idle is ignored
        @(negedge clk);
        fill_valid = 1'b1; fill_vpn = 20'h0BEEF; fill_ppn = 20'h0CAFE;
        #4;
        chk("R9 stray fill gives no response", 32'(rsp_valid), 32'd0);
        @(posedge clk); #1 fill_valid = 1'b0;
        chk_counts("R9");
        lookup(32'h0BEE_F000, 1'b0, h);
        chk("R9 stray fill installed nothing", 32'(h), 32'd0);
        walk(20'h0BEEF, 20'h0CAFE, 1'b1, 1'b0);

        // R8: lookup with flush answered from old contents, then empty
        lookup(32'h0000_1234, 1'b1, h);
        chk("R8 lookup in flush cycle hits", 32'(h), 32'd1);
        lookup(32'h0000_1234, 1'b0, h);
        chk("R8 flushed entry misses", 32'(h), 32'd0);
        walk(20'h00001, 20'h0B000, 1'b0, 1'b1);
        lookup(32'h0000_1234, 1'b0, h);
        chk("R8 fill during flush installs nothing", 32'(h), 32'd0);
        walk(20'h00001, 20'h0B000, 1'b0, 1'b0);

        // sweep: seven pages over four slots, faults and flushes interleaved
        s = 32'h1ACE_0001;
        for (int it = 0; it < 400; it++) begin
            int k;
            s = s * 32'd1103515245 + 32'd12345;
            k = int'((s >> 16) % 7);
            access({pool[k], s[11:0]}, (it % 11) == 5);
            if ((it % 97) == 50) do_flush();
        end
        chk("R7 hit counter saturated", 32'(hit_count), 32'(CMAX));
        chk("R7 miss counter saturated", 32'(miss_count), 32'(CMAX));

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule